// File: doc/BRIEF.md
# PHY Status-Change Interrupt Controller

This block turns per-port physical-layer status into one interrupt request. Every port supplies four status inputs: link up, full duplex, auto-negotiation state and a medium attachment error. The block keeps a registered copy of each input. When any port's input differs from its copy, the block sets a sticky flag for that condition class. Each of the four flags has its own enable. The flags and their enables share one status register that is read over the management path. A read of that register clears the flags.

A separate control register holds two bits. One is a global interrupt enable and the other selects AUI mode for port 0. Together they decide how a shared package pin is used. When the global enable is set, the pin is the active-low, open-drain interrupt output. When the global enable is clear and AUI mode is set, the pin becomes the negative leg of the AUI collision input pair. In the remaining case the pin is left idle. The block also tells the companion collision pin when to act as a single-ended collision input. The serial management protocol and the analog collision receiver lie outside this block.

Top module: `phy_irq_ctrl`

## Requirements
- R1: Reset clears all flags, enables and control bits. After reset the pin is not pulled low, the pin mode is idle (0) and both registers read 0.
- R2: A change on any port of a condition sets that condition's flag, visible one clock edge after the change. The flag bits in status register 16 are: bit 0 link, bit 1 duplex, bit 2 auto-negotiation, bit 3 medium error.
- R3: A flag stays set until status register 16 is read. The read clears it, and a second read with no new change returns 0 in bits 3:0.
- R4: A change in the same cycle as a read of register 16 leaves its flag set after the read.
- R5: The pin is pulled low (pin_drive_low_o=1) exactly when some flag is set, its enable is 1 and the global enable is 1. Otherwise the driver is off.
- R6: Enables sit in bits 7:4 of register 16, in the same condition order as the flags. A write to register 16 loads only the enables; the flag bits written are ignored.
- R7: Control register 18 holds the global interrupt enable in bit 5 and AUI mode in bit 2. A read returns those two bits and 0 elsewhere.
- R8: The pin mode is 1 (interrupt) when the global enable is 1. It is 2 (collision input) when the global enable is 0 and AUI mode is 1, and it is 0 otherwise. ci_neg_o follows the pad input only in mode 2 and is 0 in every other mode.
- R9: pseudo_col_o, the single-ended select for the companion collision pin, is 1 exactly when both the global enable and AUI mode are 1.
- R10: The first sample after reset loads the copies and sets no flag, even when status inputs are already high.
- R11: Flags are set whether or not their enables are 1. Enables only gate the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| link_i | input | NUM_PORTS | Per-port link-up status |
| duplex_i | input | NUM_PORTS | Per-port full-duplex status |
| aneg_i | input | NUM_PORTS | Per-port auto-negotiation state |
| mau_err_i | input | NUM_PORTS | Per-port medium attachment error |
| reg_addr_i | input | ADDR_W | Management register address |
| reg_rd_i | input | 1 | Read strobe; a strobe to register 16 clears the flags |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data for the addressed register |
| pin_in_i | input | 1 | Value sensed at the shared pad |
| pin_drive_low_o | output | 1 | 1 pulls the shared pad low; 0 leaves it undriven |
| pin_mode_o | output | 2 | Shared pin use: 0 idle, 1 interrupt, 2 collision input |
| ci_neg_o | output | 1 | Collision negative leg taken from the pad |
| pseudo_col_o | output | 1 | Companion pin runs as a single-ended collision input |

## Verification
A table of single-bit toggles walks every condition class across different ports with all enables off. It shows that each condition sets only its own flag bit, whichever port moved, and that the pin stays quiet while the flags are set. Directed sequences then turn the enables and the global bit on and off one by one, so that the flag, the enable and the global enable can each be seen gating the pin on its own. A change timed onto the very cycle of a clearing read separates a correct read-clear from one that drops new events. The four combinations of the two control bits, with the pad input toggled, show which mode owns the pin and which collision outputs follow it.

// File: rtl/phy_irq_pkg.sv
package phy_irq_pkg;
    localparam int NUM_COND  = 4;
    localparam int COND_LINK = 0;
    localparam int COND_DUP  = 1;
    localparam int COND_ANEG = 2;
    localparam int COND_MAU  = 3;
    localparam int EN_LSB    = 4;
    localparam int AUI_BIT   = 2;
    localparam int GEN_BIT   = 5;

    typedef enum logic [1:0] {
        PIN_IDLE = 2'd0,
        PIN_IRQ  = 2'd1,
        PIN_COLL = 2'd2
    } pin_mode_e;
endpackage

// File: rtl/phy_irq_chg_det.sv
module phy_irq_chg_det #(
    parameter int NUM_PORTS = 4
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [NUM_PORTS-1:0] stat_i,
    output logic                 chg_o
);
    typedef struct packed {
        logic [NUM_PORTS-1:0] copy;
        logic                 primed;
    } det_t;

    det_t det_d, det_q;

    always_comb begin
        det_d        = det_q;
        det_d.copy   = stat_i;
        det_d.primed = 1'b1;
        chg_o        = det_q.primed && (stat_i != det_q.copy);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            det_q <= '0;
        end else begin
            det_q <= det_d;
        end
    end
endmodule

// File: rtl/phy_irq_pinmux.sv
module phy_irq_pinmux
    import phy_irq_pkg::*;
(
    input  logic       gen_en_i,
    input  logic       aui_mode_i,
    input  logic       irq_req_i,
    input  logic       pin_in_i,
    output logic       pin_drive_low_o,
    output logic [1:0] pin_mode_o,
    output logic       ci_neg_o,
    output logic       pseudo_col_o
);
    pin_mode_e mode;

    always_comb begin
        if (gen_en_i) begin
            mode = PIN_IRQ;
        end else if (aui_mode_i) begin
            mode = PIN_COLL;
        end else begin
            mode = PIN_IDLE;
        end
        pin_mode_o      = mode;
        pin_drive_low_o = (mode == PIN_IRQ) && irq_req_i;
        ci_neg_o        = (mode == PIN_COLL) && pin_in_i;
        pseudo_col_o    = gen_en_i && aui_mode_i;
    end
endmodule

// File: rtl/phy_irq_ctrl.sv
module phy_irq_ctrl
    import phy_irq_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int ADDR_W    = 5,
    parameter int DATA_W    = 16,
    parameter int STAT_ADDR = 16,
    parameter int CTRL_ADDR = 18
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [NUM_PORTS-1:0] link_i,
    input  logic [NUM_PORTS-1:0] duplex_i,
    input  logic [NUM_PORTS-1:0] aneg_i,
    input  logic [NUM_PORTS-1:0] mau_err_i,
    input  logic [ADDR_W-1:0]    reg_addr_i,
    input  logic                 reg_rd_i,
    input  logic                 reg_wr_i,
    input  logic [DATA_W-1:0]    reg_wdata_i,
    output logic [DATA_W-1:0]    reg_rdata_o,
    input  logic                 pin_in_i,
    output logic                 pin_drive_low_o,
    output logic [1:0]           pin_mode_o,
    output logic                 ci_neg_o,
    output logic                 pseudo_col_o
);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
    localparam int                EN_MSB = EN_LSB + NUM_COND - 1;

    typedef struct packed {
        logic [NUM_COND-1:0] flags;
        logic [NUM_COND-1:0] en;
        logic                gen;
        logic                aui;
    } irq_state_t;

    irq_state_t st_d, st_q;

    logic [NUM_COND-1:0][NUM_PORTS-1:0] stat_all;
    logic [NUM_COND-1:0]                cond_chg;
    logic                               stat_rd;
    logic                               stat_wr;
    logic                               ctrl_wr;
    logic                               irq_req;
    logic                               unused_wdata;

    assign stat_all[COND_LINK] = link_i;
    assign stat_all[COND_DUP]  = duplex_i;
    assign stat_all[COND_ANEG] = aneg_i;
    assign stat_all[COND_MAU]  = mau_err_i;

    for (genvar c = 0; c < NUM_COND; c++) begin : g_det
        phy_irq_chg_det #(
            .NUM_PORTS(NUM_PORTS)
        ) u_det (
            .clk_i (clk_i),
            .rst_ni(rst_ni),
            .stat_i(stat_all[c]),
            .chg_o (cond_chg[c])
        );
    end

    assign stat_rd      = reg_rd_i && (reg_addr_i == STAT_A);
    assign stat_wr      = reg_wr_i && (reg_addr_i == STAT_A);
    assign ctrl_wr      = reg_wr_i && (reg_addr_i == CTRL_A);
    assign unused_wdata = ^reg_wdata_i;

    always_comb begin
        st_d = st_q;
        // a read clears, but changes seen this cycle are merged back in
        st_d.flags = (stat_rd ? '0 : st_q.flags) | cond_chg;
        if (stat_wr) begin
            st_d.en = reg_wdata_i[EN_MSB:EN_LSB];
        end
        if (ctrl_wr) begin
            st_d.gen = reg_wdata_i[GEN_BIT];
            st_d.aui = reg_wdata_i[AUI_BIT];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata_o = '0;
        if (reg_addr_i == STAT_A) begin
            reg_rdata_o[NUM_COND-1:0]  = st_q.flags;
            reg_rdata_o[EN_MSB:EN_LSB] = st_q.en;
        end else if (reg_addr_i == CTRL_A) begin
            reg_rdata_o[GEN_BIT] = st_q.gen;
            reg_rdata_o[AUI_BIT] = st_q.aui;
        end
    end

    assign irq_req = |(st_q.flags & st_q.en);

    phy_irq_pinmux u_pinmux (
        .gen_en_i       (st_q.gen),
        .aui_mode_i     (st_q.aui),
        .irq_req_i      (irq_req),
        .pin_in_i       (pin_in_i),
        .pin_drive_low_o(pin_drive_low_o),
        .pin_mode_o     (pin_mode_o),
        .ci_neg_o       (ci_neg_o),
        .pseudo_col_o   (pseudo_col_o)
    );
endmodule

// File: rtl/phy_irq_ctrl_chk.sv
module phy_irq_ctrl_chk
    import phy_irq_pkg::*;
#(
    parameter int NUM_COND_P = 4
) (
    input logic                  clk_i,
    input logic                  rst_ni,
    input logic                  stat_rd,
    input logic [NUM_COND_P-1:0] cond_chg,
    input logic [NUM_COND_P-1:0] flags,
    input logic                  gen,
    input logic                  pin_drive_low_o,
    input logic [1:0]            pin_mode_o,
    input logic                  ci_neg_o
);
    // R2: a seen change lands in its flag at the next edge
    p_change_sets_flag_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cond_chg != '0) |=> ((flags & $past(cond_chg)) == $past(cond_chg)));

    // R3: without a read, set flags stay set
    p_flag_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !stat_rd |=> ((flags & $past(flags)) == $past(flags)));

    // R3: a read with no coincident change empties the flags
    p_read_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stat_rd && cond_chg == '0) |=> (flags == '0));

    // R4: a change coincident with a read survives it
    p_read_keeps_new_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stat_rd && cond_chg != '0) |=> (flags == $past(cond_chg)));

    // R5: the pin is only pulled while the global enable is on and a flag is set
    p_pull_needs_gen_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pin_drive_low_o |-> (gen && flags != '0));

    // R8: pulling happens only in interrupt mode; collision leg quiet elsewhere
    p_pull_in_irq_mode_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pin_drive_low_o |-> (pin_mode_o == PIN_IRQ));
    p_ci_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pin_mode_o != PIN_COLL) |-> !ci_neg_o);
endmodule

bind phy_irq_ctrl phy_irq_ctrl_chk #(
    .NUM_COND_P(phy_irq_pkg::NUM_COND)
) u_chk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .stat_rd        (stat_rd),
    .cond_chg       (cond_chg),
    .flags          (st_q.flags),
    .gen            (st_q.gen),
    .pin_drive_low_o(pin_drive_low_o),
    .pin_mode_o     (pin_mode_o),
    .ci_neg_o       (ci_neg_o)
);

// File: tb/phy_irq_ctrl_bench.sv
`timescale 1ns/1ps
module phy_irq_ctrl_bench;
    localparam int NP = 4;

    logic          clk_i = 1'b0;
    logic          rst_ni = 1'b0;
    logic [NP-1:0] link_i = '0, duplex_i = '0, aneg_i = '0, mau_err_i = '0;
    logic [4:0]    reg_addr_i = '0;
    logic          reg_rd_i = 1'b0, reg_wr_i = 1'b0;
    logic [15:0]   reg_wdata_i = '0;
    logic [15:0]   reg_rdata_o;
    logic          pin_in_i = 1'b0;
    logic          pin_drive_low_o;
    logic [1:0]    pin_mode_o;
    logic          ci_neg_o;
    logic          pseudo_col_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    logic [15:0] rv;

    phy_irq_ctrl u_phy_irq_ctrl (.*);

    always #10 clk_i = ~clk_i;

    always @(posedge clk_i) begin
        cycles <= cycles + 1;
        if (cycles == 100000) begin
            failures = failures + 1;
            $display("FAIL watchdog expired act=%0d exp=<100000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk_i);
    endtask

    task automatic rd_reg(input logic [4:0] a, output logic [15:0] v);
        reg_addr_i = a;
        reg_rd_i   = 1'b1;
        #1 v = reg_rdata_o;
        @(negedge clk_i);
        reg_rd_i = 1'b0;
    endtask

    task automatic peek_reg(input logic [4:0] a, output logic [15:0] v);
        reg_addr_i = a;
        #1 v = reg_rdata_o;
    endtask

    task automatic wr_reg(input logic [4:0] a, input logic [15:0] d);
        reg_addr_i  = a;
        reg_wdata_i = d;
        reg_wr_i    = 1'b1;
        @(negedge clk_i);
        reg_wr_i = 1'b0;
    endtask

    task automatic flip(input int c, input int p);
        case (c)
            0: link_i[p]    = ~link_i[p];
            1: duplex_i[p]  = ~duplex_i[p];
            2: aneg_i[p]    = ~aneg_i[p];
            default: mau_err_i[p] = ~mau_err_i[p];
        endcase
    endtask

    // {condition[3:2], port[1:0]}
    localparam logic [3:0] VEC [8] = '{
        4'b00_00, 4'b01_11, 4'b10_01, 4'b11_10,
        4'b00_11, 4'b01_00, 4'b10_10, 4'b11_01
    };

    initial begin
        link_i = 4'b1111;
        aneg_i = 4'b0101;
        tick(2);
        #1;
        check("R1 reset pin drive", {15'd0, pin_drive_low_o}, 16'd0);
        check("R1 reset pin mode", {14'd0, pin_mode_o}, 16'd0);
        @(negedge clk_i);
        rst_ni = 1'b1;
        tick(3);
        rd_reg(5'd16, rv);
        check("R10 no flag from first sample", rv, 16'h0000);
        peek_reg(5'd18, rv);
        check("R1 control reg after reset", rv, 16'h0000);

        for (int i = 0; i < 8; i++) begin
            flip(int'(VEC[i][3:2]), int'(VEC[i][1:0]));
            tick(1);
            #1;
            check("R11 pin quiet with enables off", {15'd0, pin_drive_low_o}, 16'd0);
            rd_reg(5'd16, rv);
            check("R2 flag of changed condition", rv, 16'(1 << VEC[i][3:2]));
        end
        rd_reg(5'd16, rv);
        check("R3 second read is clear", rv, 16'h0000);

        wr_reg(5'd16, 16'h00FF);
        peek_reg(5'd16, rv);
        check("R6 enables load, flag bits ignored", rv, 16'h00F0);

        flip(1, 2);
        tick(3);
        #1;
        check("R5 pin off while global enable 0", {15'd0, pin_drive_low_o}, 16'd0);
        wr_reg(5'd18, 16'hFFFF);
        #1;
        check("R5 pin pulled with flag, enable, global", {15'd0, pin_drive_low_o}, 16'd1);
        check("R8 interrupt mode", {14'd0, pin_mode_o}, 16'd1);
        check("R9 companion single-ended", {15'd0, pseudo_col_o}, 16'd1);
        peek_reg(5'd18, rv);
        check("R7 control readback", rv, 16'h0024);
        tick(5);
        #1;
        check("R3 pin still pulled, flag sticky", {15'd0, pin_drive_low_o}, 16'd1);

        wr_reg(5'd16, 16'h00D0);
        #1;
        check("R5 pin off when the flag's enable is 0", {15'd0, pin_drive_low_o}, 16'd0);
        rd_reg(5'd16, rv);
        check("R3 read shows pending duplex flag", rv, 16'h00D2);

        flip(3, 0);
        rd_reg(5'd16, rv);
        check("R4 coincident read shows old flags", rv, 16'h00D0);
        rd_reg(5'd16, rv);
        check("R4 coincident change kept", rv, 16'h00D8);
        peek_reg(5'd16, rv);
        check("R3 cleared after read", rv, 16'h00D0);

        wr_reg(5'd18, 16'h0004);
        pin_in_i = 1'b1;
        #1;
        check("R8 collision mode", {14'd0, pin_mode_o}, 16'd2);
        check("R8 ci follows pad high", {15'd0, ci_neg_o}, 16'd1);
        check("R9 companion differential", {15'd0, pseudo_col_o}, 16'd0);
        pin_in_i = 1'b0;
        #1;
        check("R8 ci follows pad low", {15'd0, ci_neg_o}, 16'd0);
        wr_reg(5'd18, 16'h0000);
        pin_in_i = 1'b1;
        #1;
        check("R8 idle mode", {14'd0, pin_mode_o}, 16'd0);
        check("R8 ci quiet in idle", {15'd0, ci_neg_o}, 16'd0);
        wr_reg(5'd18, 16'h0020);
        #1;
        check("R9 no single-ended without AUI", {15'd0, pseudo_col_o}, 16'd0);
        check("R8 ci quiet in interrupt mode", {15'd0, ci_neg_o}, 16'd0);

        flip(0, 1);
        tick(1);
        rst_ni = 1'b0;
        #1;
        check("R1 reset releases pin", {15'd0, pin_drive_low_o}, 16'd0);
        tick(1);
        rst_ni = 1'b1;
        tick(2);
        peek_reg(5'd16, rv);
        check("R1 status reg after reset", rv, 16'h0000);
        peek_reg(5'd18, rv);
        check("R1 control reg after reset", rv, 16'h0000);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule